// File: doc/BRIEF.md
# Video Event Interrupt Controller

This block sits between a video generator and a host processor. It turns frame and object events into a single interrupt request. Frame events come from the vertical reset level. Object events are completion and collision strobes for four objects. The block keeps two cause registers that the host reads to find out why it was interrupted. When the processor acknowledges, the block places a fixed vector byte on the data bus, and the host branches to the handler through that byte.

All event inputs come from another timing domain. Each one passes through a two-stage synchronizer, and the block acts on the rising or falling edge of the synchronized level. The pending request is withdrawn only when the vertical reset ends. Reading a cause register empties it. A handler must therefore act on every bit it reads, or save those bits, before it reads again.

Top module: `vidirq_ctrl`

## Requirements
- R1: A rising edge of `vrst_in` sets `irq_out` to 1.
- R2: A rising edge of `obj_done_in[i]` sets `irq_out` to 1 and sets bit i (bits 3:0) of the object register, which is read at `rd_addr` = 0.
- R3: A falling edge of `vrst_in` clears `irq_out` and clears every bit of both registers. The exception is an event edge in the same cycle, which still sets its bit.
- R4: While `iack_in` is 1, `vec_oe` is 1 and `vec_data` is 8'h03 in the same cycle. While `iack_in` is 0, `vec_oe` is 0 and `vec_data` is 8'h00.
- R5: A rising edge of `coll_in[i]` sets bit 4+i of the object register and does not change `irq_out`.
- R6: A rising edge of `vrst_in` sets bit 0 of the frame register, which is read at `rd_addr` = 1. Bits 7:1 of the frame register always read 0.
- R7: A cycle with `rd_en` high loads the addressed register into `rd_data` at that clock edge. It clears that register and leaves the other register and `irq_out` unchanged. `rd_data` holds its value while `rd_en` is low.
- R8: An event edge in the same cycle as a read of its register is not lost. After the read, that register holds only the new bit.
- R9: Each input change takes effect at the third rising clock edge after the change.
- R10: After reset, `irq_out` is 0, both registers are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| vrst_in | input | 1 | Vertical reset level, asynchronous |
| obj_done_in | input | 4 | Object completion strobes, asynchronous |
| coll_in | input | 4 | Object/background collision strobes, asynchronous |
| iack_in | input | 1 | Processor interrupt acknowledge |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Register select: 0 object, 1 frame |
| rd_data | output | 8 | Registered read data |
| irq_out | output | 1 | Interrupt request, active high |
| vec_data | output | 8 | Vector byte, gated by acknowledge |
| vec_oe | output | 1 | Bus drive enable for the vector |

## Verification
A lost or stray cause bit shows up on `rd_data` one cycle after the next read of its register. A stuck request shows up on `irq_out` at the third edge after a vertical-reset edge. If the edge detector holds the wrong history, an event is either missed or counted twice. The bench sees this in the first read after the event. If the clear logic gives the wrong priority, the coincident-read case returns an empty register where a bit is expected.

// File: rtl/vidirq_pkg.sv
package vidirq_pkg;
    localparam int NOBJ      = 4;
    localparam int DW        = 8;
    localparam int SYNC_W    = 2 * NOBJ + 1;
    localparam logic [DW-1:0] VECTOR = 8'h03;

    typedef enum logic { SEL_OBJ = 1'b0, SEL_FRAME = 1'b1 } reg_sel_e;

    typedef struct packed {
        logic [NOBJ-1:0] coll;
        logic [NOBJ-1:0] done;
    } obj_stat_t;

    function automatic logic [DW-1:0] pad_frame(input logic f);
        return {{(DW-1){1'b0}}, f};
    endfunction
endpackage

// File: rtl/vidirq_sync.sv
module vidirq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, hist;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                hist <= 1'b0;
            end else begin
                s1   <= din[i];
                s2   <= s1;
                hist <= s2;
            end
        end
        assign lvl[i]  = s2;
        assign prev[i] = hist;
    end
endmodule

// File: rtl/vidirq_status.sv
module vidirq_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_rd,
    input  logic         clr_vrst,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)                   q <= '0;
        else if (clr_rd || clr_vrst) q <= set;
        else                       q <= q | set;
    end

    // R7/R3: a clear with no new event empties the register
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ((clr_rd || clr_vrst) && set == '0) |=> q == '0);
    // R8: a new event survives any clear in the same cycle
    assert_event_survives_R8: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/vidirq_ctrl.sv
module vidirq_ctrl
    import vidirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            vrst_in,
    input  logic [NOBJ-1:0] obj_done_in,
    input  logic [NOBJ-1:0] coll_in,
    input  logic            iack_in,
    input  logic            rd_en,
    input  logic            rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            irq_out,
    output logic [DW-1:0]   vec_data,
    output logic            vec_oe
);
    logic [SYNC_W-1:0] lvl, prev, rise;
    logic              vrst_rise, vrst_fall;
    obj_stat_t         obj_set, obj_q;
    logic              frame_q;
    reg_sel_e          sel;
    logic              rd_obj, rd_frame;

    vidirq_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({coll_in, obj_done_in, vrst_in}),
        .lvl (lvl),
        .prev(prev)
    );

    assign rise      = lvl & ~prev;
    assign vrst_rise = rise[0];
    assign vrst_fall = ~lvl[0] & prev[0];
    assign obj_set   = '{coll: rise[2*NOBJ:NOBJ+1], done: rise[NOBJ:1]};

    assign sel      = reg_sel_e'(rd_addr);
    assign rd_obj   = rd_en && (sel == SEL_OBJ);
    assign rd_frame = rd_en && (sel == SEL_FRAME);

    vidirq_status #(.W(DW)) u_obj_stat (
        .clk     (clk),
        .rst     (rst),
        .set     (obj_set),
        .clr_rd  (rd_obj),
        .clr_vrst(vrst_fall),
        .q       (obj_q)
    );

    vidirq_status #(.W(1)) u_frame_stat (
        .clk     (clk),
        .rst     (rst),
        .set     (vrst_rise),
        .clr_rd  (rd_frame),
        .clr_vrst(vrst_fall),
        .q       (frame_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                              irq_out <= 1'b0;
        else if (vrst_rise || |obj_set.done)  irq_out <= 1'b1;
        else if (vrst_fall)                   irq_out <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)       rd_data <= '0;
        else if (rd_en) rd_data <= (sel == SEL_FRAME) ? pad_frame(frame_q) : obj_q;
    end

    assign vec_oe   = iack_in;
    assign vec_data = iack_in ? VECTOR : '0;

    assert_vrst_raises_R1: assert property (@(posedge clk) disable iff (rst)
        vrst_rise |=> irq_out);
    assert_obj_raises_R2: assert property (@(posedge clk) disable iff (rst)
        (|obj_set.done) |=> irq_out);
    assert_vrst_end_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (vrst_fall && !(|obj_set.done)) |=> (!irq_out && obj_q == $past(obj_set) && !frame_q));
    assert_vector_R4: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> vec_data == VECTOR);
    assert_read_keeps_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !vrst_fall && !vrst_rise && !(|obj_set.done)) |=> $stable(irq_out));
endmodule

// File: tb/vidirq_ctrl_tb.sv
module vidirq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       vrst_in;
    logic [3:0] obj_done_in, coll_in;
    logic       iack_in, rd_en, rd_addr;
    logic [7:0] rd_data, vec_data;
    logic       irq_out, vec_oe;
    int         n_chk = 0, n_fail = 0;
    bit         done_flag = 1'b0;

    always #2.5 clk = ~clk;

    vidirq_ctrl u_dut (
        .clk(clk), .rst(rst), .vrst_in(vrst_in), .obj_done_in(obj_done_in),
        .coll_in(coll_in), .iack_in(iack_in), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_out(irq_out), .vec_data(vec_data), .vec_oe(vec_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input logic a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        step(1);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic pulse_obj(input int i);
        obj_done_in[i] = 1'b1; step(3);
        obj_done_in[i] = 1'b0; step(3);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst = 1'b1; vrst_in = 0; obj_done_in = 0; coll_in = 0;
        iack_in = 0; rd_en = 0; rd_addr = 0;
        step(4);
        rst = 1'b0; step(1);
        check("R10 irq", {7'b0, irq_out}, 8'h00);
        check("R10 rd_data", rd_data, 8'h00);
        do_read(1'b0, v); check("R10 obj reg", v, 8'h00);
        do_read(1'b1, v); check("R10 frame reg", v, 8'h00);
    endtask

    task automatic t_frame;
        logic [7:0] v;
        vrst_in = 1'b1; step(2);
        check("R9 not before third edge", {7'b0, irq_out}, 8'h00);
        step(1);
        check("R1 irq on vrst rise", {7'b0, irq_out}, 8'h01);
        do_read(1'b1, v); check("R6 frame bit0", v, 8'h01);
        do_read(1'b1, v); check("R7 frame cleared by read", v, 8'h00);
        check("R7 read leaves irq", {7'b0, irq_out}, 8'h01);
        vrst_in = 1'b0; step(3);
        check("R3 irq dropped on vrst fall", {7'b0, irq_out}, 8'h00);
    endtask

    task automatic t_obj;
        logic [7:0] v;
        pulse_obj(2);
        check("R2 irq on obj done", {7'b0, irq_out}, 8'h01);
        pulse_obj(0);
        do_read(1'b1, v); check("R7 other reg read", v, 8'h00);
        do_read(1'b0, v); check("R2 obj bits 0 and 2", v, 8'h05);
        check("R7 rd_data holds", rd_data, 8'h05);
        step(2); check("R7 rd_data still held", rd_data, 8'h05);
        do_read(1'b0, v); check("R7 obj cleared", v, 8'h00);
        pulse_obj(3);
        vrst_in = 1'b1; step(4);
        vrst_in = 1'b0; step(3);
        check("R3 irq clear", {7'b0, irq_out}, 8'h00);
        do_read(1'b0, v); check("R3 obj reg cleared", v, 8'h00);
        do_read(1'b1, v); check("R3 frame reg cleared", v, 8'h00);
    endtask

    task automatic t_coll;
        logic [7:0] v;
        coll_in = 4'b1001; step(3); coll_in = 0; step(3);
        check("R5 no irq from collision", {7'b0, irq_out}, 8'h00);
        do_read(1'b0, v); check("R5 collision bits 4 and 7", v, 8'h90);
    endtask

    task automatic t_same;
        logic [7:0] v;
        pulse_obj(0);
        obj_done_in[1] = 1'b1; step(2);
        do_read(1'b0, v); check("R8 read returns old", v, 8'h01);
        obj_done_in[1] = 1'b0;
        do_read(1'b0, v); check("R8 new bit kept", v, 8'h02);
        vrst_in = 1'b1; step(4);
        vrst_in = 1'b0; step(2);
        obj_done_in[3] = 1'b1; step(1);
        check("R3 irq dropped at fall", {7'b0, irq_out}, 8'h00);
        step(2); obj_done_in[3] = 1'b0; step(3);
        do_read(1'b0, v); check("R3 later event kept", v, 8'h08);
    endtask

    task automatic t_vector;
        check("R4 idle oe", {7'b0, vec_oe}, 8'h00);
        check("R4 idle data", vec_data, 8'h00);
        iack_in = 1'b1; #1;
        check("R4 ack oe", {7'b0, vec_oe}, 8'h01);
        check("R4 ack vector", vec_data, 8'h03);
        iack_in = 1'b0; #1;
        check("R4 released", vec_data, 8'h00);
        step(1);
    endtask

    initial begin
        t_reset();
        t_frame();
        t_obj();
        t_coll();
        t_same();
        t_vector();
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule